// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous, address-multiplexed DRAM alive. Once reset is released it holds off all traffic for a configurable start-up delay. It then asks the memory arbiter for a fixed number of initialization refresh cycles. After that it raises one refresh request per refresh interval, which spreads the array's refresh load evenly. All delays are given in nanoseconds and are rounded up to whole clock cycles.

Each refresh is a CAS-before-RAS cycle, so the DRAM takes the row from its own internal counter and no address is driven. The scheduler has a simple request/grant exchange with the arbiter. When a grant arrives, the scheduler runs the strobe sequence itself: a RAS precharge stretch, then every CAS byte strobe goes low, then RAS goes low for a fixed time, then all strobes are released.

Refreshes that the arbiter postpones are counted. The count is reported to the arbiter, and an urgency flag is raised when the count reaches its limit. A further postponement at that point sets a sticky error flag.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted: `ras_n` and all `cas_n` lanes are high; `ref_req`, `ref_ack`, `init_done`, `ovf_err` and `ref_urgent` are low; `ref_pending` is 0.
- R2: After reset is released, `ref_req` stays low for WAIT_CYC = ceil(STARTUP_NS*1000/CLK_PS) clock cycles. It first reads high after exactly WAIT_CYC rising edges.
- R3: During initialization, exactly INIT_CYCLES refresh sequences complete while `init_done` is low. `init_done` rises in the same cycle as the `ref_ack` of the last of these sequences and then stays high until reset. `ref_pending` stays 0 while `init_done` is low.
- R4: All CAS lanes switch together. They are low for exactly CSU_CYC = ceil(CAS_SETUP_NS) cycles before RAS falls, stay low for as long as RAS is low, and rise in the same cycle as RAS.
- R5: Before RAS falls, it has been high for at least PRE_CYC + CSU_CYC cycles, where PRE_CYC = ceil(PRECHARGE_NS). RAS is then low for exactly RASL_CYC = max(ceil(RAS_MIN_NS), ceil(CAS_HOLD_NS)) cycles. Every value here is rounded in clock cycles.
- R6: A sequence starts on the rising edge where both `ref_req` and `ref_gnt` are high. RAS falls PRE_CYC+CSU_CYC edges later. `ref_req` stays low while a sequence runs. `ref_ack` is high for one cycle only: the first cycle in which RAS is high again. After initialization, when no sequence is running, `ref_req` is high exactly when `ref_pending` is nonzero.
- R7: Once `init_done` rises, a refresh becomes due every INT_CYC = ceil(INTERVAL_NS) cycles, with the first one due INT_CYC edges after the rise. Each due refresh increments `ref_pending`.
- R8: After initialization, each completed sequence decrements `ref_pending`. If a due refresh and a completion fall on the same edge, `ref_pending` does not change.
- R9: `ref_urgent` is high exactly when `ref_pending` equals MAX_PENDING.
- R10: If a refresh becomes due while `ref_pending` equals MAX_PENDING and no sequence completes on that edge, `ref_pending` stays at MAX_PENDING and `ovf_err` goes high. `ovf_err` then stays high until reset, including after the backlog has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grants the DRAM bus for one refresh sequence |
| ref_req | output | 1 | Refresh work is waiting and the sequencer is idle |
| ref_urgent | output | 1 | Postponement limit reached; the arbiter should grant first |
| ref_ack | output | 1 | One-cycle pulse when a refresh sequence finishes |
| ref_pending | output | $clog2(MAX_PENDING+1) | Number of postponed refreshes |
| init_done | output | 1 | Start-up wait and initialization burst are complete |
| ovf_err | output | 1 | Sticky flag: a refresh was lost to backlog overflow |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | CAS_LANES | Column strobes for each byte lane, active low |

## Verification
The interesting collision is a due refresh tick landing on the same edge as the last RAS-low cycle of a sequence. If the block gets it wrong, the backlog count can drift. The bench provokes this by sweeping the arbiter's grant delay one cycle further on every grant, so completions move across every phase of the refresh interval. On each cycle it compares `ref_pending` with its own tally of ticks and completions, and it requires that at least one collision was actually observed. A second, rarer pairing is an overflow tick with the counter at its limit. This is forced by withholding grants and is judged on the counter, the urgency flag and the sticky error.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_CSU,
    SQ_RASL
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_WAIT,
    PH_INIT,
    PH_RUN
  } phase_e;

  // Round a duration in ns up to whole clocks of clk_ps picoseconds, minimum 1.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    longint unsigned q;
    q = (64'(ns) * 64'd1000 + 64'(clk_ps) - 64'd1) / 64'(clk_ps);
    if (q == 64'd0) q = 64'd1;
    return 32'(q);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Counter width able to hold values 0..n-1, at least one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer
  import dram_ref_pkg::*;
#(
  parameter int unsigned INT_CYC = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int unsigned CW = cnt_width(INT_CYC);
  localparam logic [CW-1:0] LAST = CW'(INT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);

endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int unsigned MAX_PENDING = 8,
  localparam int unsigned PW = $clog2(MAX_PENDING + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] count,
  output logic          urgent,
  output logic          ovf
);

  localparam logic [PW-1:0] MAXV = PW'(MAX_PENDING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (inc && !dec) begin
      if (count == MAXV) ovf <= 1'b1;
      else               count <= count + 1'b1;
    end else if (dec && !inc && count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign urgent = (count == MAXV);

endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
  import dram_ref_pkg::*;
#(
  parameter int unsigned PRE_CYC   = 8,
  parameter int unsigned CSU_CYC   = 1,
  parameter int unsigned RASL_CYC  = 12,
  parameter int unsigned CAS_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 last,
  output logic                 ras_n,
  output logic [CAS_LANES-1:0] cas_n
);

  localparam int unsigned LONGEST = max2(max2(PRE_CYC, CSU_CYC), RASL_CYC);
  localparam int unsigned CW = cnt_width(LONGEST);

  seq_state_e    st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          ras_q;
  logic          cas_on_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      SQ_IDLE: if (start) begin
        st_nx  = SQ_PRE;
        cnt_nx = CW'(PRE_CYC - 1);
      end
      SQ_PRE: if (cnt == '0) begin
        st_nx  = SQ_CSU;
        cnt_nx = CW'(CSU_CYC - 1);
      end else begin
        cnt_nx = cnt - 1'b1;
      end
      SQ_CSU: if (cnt == '0) begin
        st_nx  = SQ_RASL;
        cnt_nx = CW'(RASL_CYC - 1);
      end else begin
        cnt_nx = cnt - 1'b1;
      end
      SQ_RASL: if (cnt == '0) begin
        st_nx = SQ_IDLE;
      end else begin
        cnt_nx = cnt - 1'b1;
      end
      default: st_nx = SQ_IDLE;
    endcase
  end

  assign cas_on_nx = (st_nx == SQ_CSU) || (st_nx == SQ_RASL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      ras_q <= 1'b1;
    end else begin
      st    <= st_nx;
      cnt   <= cnt_nx;
      ras_q <= (st_nx != SQ_RASL);
    end
  end

  // One strobe flop per byte lane so that each pin leaves a register.
  for (genvar g = 0; g < CAS_LANES; g++) begin : g_lane
    logic cas_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cas_q <= 1'b1;
      else        cas_q <= !cas_on_nx;
    end
    assign cas_n[g] = cas_q;
  end

  assign ras_n = ras_q;
  assign busy  = (st != SQ_IDLE);
  assign last  = (st == SQ_RASL) && (cnt == '0);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_PS       = 5000,
  parameter int unsigned STARTUP_NS   = 200000,
  parameter int unsigned INTERVAL_NS  = 15625,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned PRECHARGE_NS = 40,
  parameter int unsigned RAS_MIN_NS   = 60,
  parameter int unsigned CAS_SETUP_NS = 5,
  parameter int unsigned CAS_HOLD_NS  = 10,
  parameter int unsigned MAX_PENDING  = 8,
  parameter int unsigned CAS_LANES    = 2,
  localparam int unsigned PEND_W      = $clog2(MAX_PENDING + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_gnt,
  output logic                 ref_req,
  output logic                 ref_urgent,
  output logic                 ref_ack,
  output logic [PEND_W-1:0]    ref_pending,
  output logic                 init_done,
  output logic                 ovf_err,
  output logic                 ras_n,
  output logic [CAS_LANES-1:0] cas_n
);

  localparam int unsigned WAIT_CYC = ns_to_cyc(STARTUP_NS, CLK_PS);
  localparam int unsigned INT_CYC  = ns_to_cyc(INTERVAL_NS, CLK_PS);
  localparam int unsigned PRE_CYC  = ns_to_cyc(PRECHARGE_NS, CLK_PS);
  localparam int unsigned CSU_CYC  = ns_to_cyc(CAS_SETUP_NS, CLK_PS);
  localparam int unsigned RASL_CYC = max2(ns_to_cyc(RAS_MIN_NS, CLK_PS),
                                          ns_to_cyc(CAS_HOLD_NS, CLK_PS));
  localparam int unsigned WAIT_W   = cnt_width(WAIT_CYC);
  localparam int unsigned INIT_W   = $clog2(INIT_CYCLES + 1);

  // Named internal events, observed by the bound checker.
  logic ref_tick;
  logic seq_start;
  logic seq_busy;
  logic seq_last;
  logic run_dec;
  logic need;

  phase_e            phase;
  logic [WAIT_W-1:0] wait_cnt;
  logic [INIT_W-1:0] init_left;
  logic              ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_WAIT;
      wait_cnt  <= WAIT_W'(WAIT_CYC - 1);
      init_left <= '0;
    end else begin
      case (phase)
        PH_WAIT: begin
          if (wait_cnt == '0) begin
            phase     <= PH_INIT;
            init_left <= INIT_W'(INIT_CYCLES);
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        PH_INIT: begin
          if (seq_last) begin
            init_left <= init_left - 1'b1;
            if (init_left == INIT_W'(1)) phase <= PH_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= seq_last;
  end

  assign init_done = (phase == PH_RUN);
  assign run_dec   = seq_last && init_done;
  assign need      = (phase == PH_INIT) || (init_done && ref_pending != '0);
  assign ref_req   = need && !seq_busy;
  assign seq_start = ref_req && ref_gnt;
  assign ref_ack   = ack_q;

  ref_interval_timer #(
    .INT_CYC (INT_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (init_done),
    .tick  (ref_tick)
  );

  ref_pending_ctr #(
    .MAX_PENDING (MAX_PENDING)
  ) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (ref_tick),
    .dec    (run_dec),
    .count  (ref_pending),
    .urgent (ref_urgent),
    .ovf    (ovf_err)
  );

  cbr_sequencer #(
    .PRE_CYC   (PRE_CYC),
    .CSU_CYC   (CSU_CYC),
    .RASL_CYC  (RASL_CYC),
    .CAS_LANES (CAS_LANES)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (seq_start),
    .busy  (seq_busy),
    .last  (seq_last),
    .ras_n (ras_n),
    .cas_n (cas_n)
  );

endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int unsigned MAX_PENDING = 8,
  parameter int unsigned CAS_LANES   = 2,
  parameter int unsigned RASL_CYC    = 12,
  localparam int unsigned PEND_W     = $clog2(MAX_PENDING + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ras_n,
  input logic [CAS_LANES-1:0] cas_n,
  input logic                 ref_req,
  input logic                 ref_ack,
  input logic [PEND_W-1:0]    ref_pending,
  input logic                 init_done,
  input logic                 ovf_err,
  input logic                 seq_busy,
  input logic                 seq_last,
  input logic                 tick
);

  logic [15:0] lo_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_len <= '0;
    else if (!ras_n) lo_len <= lo_len + 1'b1;
    else             lo_len <= '0;
  end

  // R4
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == '0));

  // R4
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (cas_n == '0));

  // R5
  ras_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_len == 16'(RASL_CYC)));

  // R6
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !ref_req);

  // R6
  ack_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_last |=> (ref_ack && ras_n));

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |=> !ref_ack);

  // R3
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R3
  init_pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (ref_pending == '0));

  // R7
  tick_run_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> init_done);

  // R8
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seq_last && init_done) |=> $stable(ref_pending));

  // R10
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending <= PEND_W'(MAX_PENDING));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

endmodule

bind dram_refresh_sched ref_sched_chk #(
  .MAX_PENDING (MAX_PENDING),
  .CAS_LANES   (CAS_LANES),
  .RASL_CYC    (RASL_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .ref_req     (ref_req),
  .ref_ack     (ref_ack),
  .ref_pending (ref_pending),
  .init_done   (init_done),
  .ovf_err     (ovf_err),
  .seq_busy    (seq_busy),
  .seq_last    (seq_last),
  .tick        (ref_tick)
);

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;

  localparam int CLK_PS   = 5000;
  localparam int STUP_NS  = 100;
  localparam int INTV_NS  = 400;
  localparam int PREC_NS  = 40;
  localparam int RMIN_NS  = 60;
  localparam int CSET_NS  = 5;
  localparam int CHLD_NS  = 10;
  localparam int INIT_N   = 8;
  localparam int MAXP     = 4;
  localparam int LANES    = 2;
  localparam int PW       = $clog2(MAXP + 1);

  // Smallest whole number of clocks covering ns, by counting up.
  function automatic int cyc_of(input int ns);
    int n;
    n = 0;
    while (n * CLK_PS < ns * 1000) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  localparam int WAIT_C = cyc_of(STUP_NS);
  localparam int INT_C  = cyc_of(INTV_NS);
  localparam int PRE_C  = cyc_of(PREC_NS);
  localparam int CSU_C  = cyc_of(CSET_NS);
  localparam int RASL_C = (cyc_of(RMIN_NS) > cyc_of(CHLD_NS)) ? cyc_of(RMIN_NS) : cyc_of(CHLD_NS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_gnt = 1'b0;
  logic             ref_req, ref_urgent, ref_ack, init_done, ovf_err, ras_n;
  logic [PW-1:0]    ref_pending;
  logic [LANES-1:0] cas_n;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .CLK_PS       (CLK_PS),
    .STARTUP_NS   (STUP_NS),
    .INTERVAL_NS  (INTV_NS),
    .INIT_CYCLES  (INIT_N),
    .PRECHARGE_NS (PREC_NS),
    .RAS_MIN_NS   (RMIN_NS),
    .CAS_SETUP_NS (CSET_NS),
    .CAS_HOLD_NS  (CHLD_NS),
    .MAX_PENDING  (MAXP),
    .CAS_LANES    (LANES)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_gnt     (ref_gnt),
    .ref_req     (ref_req),
    .ref_urgent  (ref_urgent),
    .ref_ack     (ref_ack),
    .ref_pending (ref_pending),
    .init_done   (init_done),
    .ovf_err     (ovf_err),
    .ras_n       (ras_n),
    .cas_n       (cas_n)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Arbiter controls, written by the main thread between edges.
  bit arb_on = 1'b0;
  bit sweep  = 1'b0;
  int arb_dly = 0;

  // Monitor and model state, owned by the monitor loop.
  int rc, wcnt, age, ras_hi, ras_lo, cas_pre, init_acks, c_since, exp_pend, collisions;
  bit prev_ras, in_seq, started_nx, req_seen, seen_init, exp_err;

  initial begin
    collisions = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        // R1 reset values
        chk(ras_n == 1'b1, "R1 ras_n", int'(ras_n), 1);
        chk(cas_n == '1, "R1 cas_n", int'(cas_n), (1 << LANES) - 1);
        chk({ref_req, ref_ack, init_done, ovf_err, ref_urgent} == 5'b0, "R1 flags",
            int'({ref_req, ref_ack, init_done, ovf_err, ref_urgent}), 0);
        chk(ref_pending == '0, "R1 pending", int'(ref_pending), 0);
        rc = 0; wcnt = 0; age = 0; ras_hi = 0; ras_lo = 0; cas_pre = 0;
        init_acks = 0; c_since = 0; exp_pend = 0;
        prev_ras = 1'b1; in_seq = 1'b0; started_nx = 1'b0; req_seen = 1'b0;
        seen_init = 1'b0; exp_err = 1'b0;
        ref_gnt = 1'b0;
      end else begin
        rc++;
        if (started_nx) begin in_seq = 1'b1; age = 0; end
        if (in_seq) age++;

        // R2 start-up wait
        if (!req_seen && ref_req) begin
          req_seen = 1'b1;
          chk(rc == WAIT_C, "R2 first request cycle", rc, WAIT_C);
        end

        // R4 lanes move together
        if (cas_n[0] != cas_n[LANES-1]) chk(1'b0, "R4 lane mismatch", int'(cas_n), 0);

        if (!ras_n) begin
          if (prev_ras) begin
            chk(cas_pre == CSU_C, "R4 CAS lead", cas_pre, CSU_C);
            chk(ras_hi >= PRE_C + CSU_C, "R5 RAS high before fall", ras_hi, PRE_C + CSU_C);
            chk(in_seq && age == PRE_C + CSU_C + 1, "R6 fall after start", age, PRE_C + CSU_C + 1);
            ras_lo = 1;
          end else begin
            ras_lo++;
          end
          if (cas_n != '0) chk(1'b0, "R4 CAS high during RAS low", int'(cas_n), 0);
          cas_pre = 0;
        end else begin
          if (!prev_ras) begin
            chk(ras_lo == RASL_C, "R5 RAS low length", ras_lo, RASL_C);
            chk(ref_ack == 1'b1, "R6 ack on RAS rise", int'(ref_ack), 1);
            chk(cas_n == '1, "R4 CAS rises with RAS", int'(cas_n), (1 << LANES) - 1);
            in_seq = 1'b0;
            ras_hi = 1;
          end else begin
            ras_hi++;
            if (ref_ack) chk(1'b0, "R6 stray ack", 1, 0);
          end
          cas_pre = (cas_n == '0) ? cas_pre + 1 : 0;
        end
        prev_ras = ras_n;

        if (in_seq && ref_req) chk(1'b0, "R6 request while busy", 1, 0);

        // R3 / R7 / R8 / R9 / R10 model
        if (seen_init) c_since++;
        if (!seen_init) begin
          if (ref_ack) init_acks++;
          chk(ref_pending == '0, "R3 pending before init", int'(ref_pending), 0);
          if (init_done) begin
            chk(init_acks == INIT_N, "R3 init sequences", init_acks, INIT_N);
            seen_init = 1'b1;
            c_since = 0;
          end
        end else begin
          bit tk, dc;
          tk = (c_since % INT_C) == 0;
          dc = ref_ack;
          if (tk && dc) collisions++;
          if (tk && !dc) begin
            if (exp_pend == MAXP) exp_err = 1'b1;
            else exp_pend++;
          end else if (dc && !tk && exp_pend > 0) begin
            exp_pend--;
          end
          chk(init_done == 1'b1, "R3 init_done held", int'(init_done), 1);
          chk(int'(ref_pending) == exp_pend, dc ? "R8 pending" : "R7 pending",
              int'(ref_pending), exp_pend);
          chk(ref_urgent == (exp_pend == MAXP), "R9 urgent", int'(ref_urgent), int'(exp_pend == MAXP));
          chk(ovf_err == exp_err, "R10 overflow flag", int'(ovf_err), int'(exp_err));
          if (!in_seq) chk(ref_req == (exp_pend > 0), "R6 request level", int'(ref_req), int'(exp_pend > 0));
        end

        // Arbiter model
        if (arb_on && ref_req) begin
          if (wcnt >= arb_dly) ref_gnt = 1'b1;
          else begin wcnt++; ref_gnt = 1'b0; end
        end else begin
          ref_gnt = 1'b0;
          wcnt = 0;
        end
        started_nx = ref_req && ref_gnt;
        if (started_nx && sweep) arb_dly = (arb_dly + 1) % 64;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    // Scenario 1: initialization, then a grant-delay sweep for tick/completion collisions.
    arb_on = 1'b1; arb_dly = 0; sweep = 1'b0;
    do_reset();
    while (!seen_init) @(posedge clk);
    sweep = 1'b1;
    repeat (70 * INT_C) @(posedge clk);
    chk(collisions > 0, "R8 collision observed", collisions, 1);
    sweep = 1'b0;

    // Scenario 2: withhold grants until overflow, then drain.
    arb_on = 1'b1; arb_dly = 2;
    do_reset();
    while (!seen_init) @(posedge clk);
    arb_on = 1'b0;
    repeat (MAXP * INT_C + 2) @(posedge clk);
    @(negedge clk);
    chk(int'(ref_pending) == MAXP, "R9 pending at limit", int'(ref_pending), MAXP);
    chk(ref_urgent == 1'b1, "R9 urgent at limit", int'(ref_urgent), 1);
    chk(ovf_err == 1'b0, "R10 no error yet", int'(ovf_err), 0);
    repeat (INT_C) @(posedge clk);
    @(negedge clk);
    chk(int'(ref_pending) == MAXP, "R10 pending saturates", int'(ref_pending), MAXP);
    chk(ovf_err == 1'b1, "R10 error raised", int'(ovf_err), 1);
    arb_on = 1'b1; arb_dly = 0;
    repeat (4 * INT_C) @(posedge clk);
    @(negedge clk);
    chk(int'(ref_pending) < MAXP, "R8 backlog drained", int'(ref_pending), 0);
    chk(ovf_err == 1'b1, "R10 error sticky", int'(ovf_err), 1);

    // Scenario 3: reset clears the sticky state.
    do_reset();
    @(negedge clk);
    chk(ovf_err == 1'b0 && ref_pending == '0, "R1 cleared after reset", int'(ovf_err), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule